// File: doc/BRIEF.md
# Framed Byte Response Transmitter

This block sends a finished response frame to a host, one byte at a time, over an 8-bit data bus. Each byte uses a four-phase SYN/ACK handshake. A command processor places the frame in a flat byte buffer, gives its length, and pulses `start_i`. The block copies the frame and the length into its own registers. It then sends every byte in order, from the start-of-response byte 0xaa through the closing end-of-response byte 0x55. When the host has released ACK after the final byte, the block raises a one-cycle `done_o`.

The host side follows these back-pressure rules:

- The byte on `tx_data_o` is valid for as long as `tx_syn_o` is high.
- The host holds off the transfer simply by not raising `tx_ack_i`.
- The block drops SYN one cycle after it samples ACK high.
- The block raises SYN for the next byte only after ACK has been sampled low.

The length counts the bytes to send, so a 0x55 value inside an address or data field does not end the frame early.

Top module: `resp_tx_top`

## Requirements
- R1: After reset `tx_syn_o`, `busy_o` and `done_o` are low. A `start_i` sampled while idle with `frame_len_i` in 1..MAX_BYTES raises `busy_o` and `tx_syn_o` in the next cycle.
- R2: While `tx_syn_o` is high, `tx_data_o` holds steady. It equals byte k of the captured frame, where byte k sits at bits [8k+7:8k] of `frame_i` and k counts from 0.
- R3: When `tx_ack_i` is sampled high while `tx_syn_o` is high, `tx_syn_o` is low in the next cycle.
- R4: `tx_syn_o` is never raised while ACK is still high. After a non-final byte, SYN rises one cycle after ACK is sampled low.
- R5: Exactly `frame_len_i` bytes are sent, in index order. A 0x55 byte before the last position does not end the frame. Frames of 3, 4, 5 and 9 bytes, starting 0xaa and ending 0x55, go out whole.
- R6: After the final byte, `done_o` is high for exactly one cycle, one cycle after ACK is sampled low. `busy_o` falls in that same cycle and stays high from acceptance until then.
- R7: A `start_i` pulse while busy is ignored. The frame and the length are captured at acceptance, so later changes on `frame_i` or `frame_len_i` do not alter the bytes sent.
- R8: A `start_i` with `frame_len_i` equal to 0 or greater than MAX_BYTES is ignored: `busy_o` and `tx_syn_o` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to send the buffered frame |
| frame_len_i | input | 4 | Number of bytes in the frame |
| frame_i | input | 72 | Frame bytes, byte k at bits [8k+7:8k] |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse when the frame is finished |
| tx_data_o | output | 8 | Byte offered to the host |
| tx_syn_o | output | 1 | Byte-valid strobe to the host |
| tx_ack_i | input | 1 | Host acknowledge |

## Verification
All outputs are registered state one edge away from the input that causes them, so each result is due in the cycle after its cause:

- `tx_syn_o` and `busy_o` come one cycle after an accepted start.
- SYN falls one cycle after ACK is seen high.
- The next byte's SYN, or `done_o` together with `busy_o` low, comes one cycle after ACK is seen low.

The bench drives inputs on falling edges and checks exactly one falling edge after each stimulus. During host-side stalls of random length, it checks at every falling edge that SYN and the data stay put.

// File: rtl/resp_tx_pkg.sv
package resp_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_OFFER   = 2'd1,
    ST_RELEASE = 2'd2
  } tx_state_e;
endpackage

// File: rtl/resp_tx_store.sv
module resp_tx_store #(
  parameter int MAX_BYTES = 9,
  parameter int LEN_W     = 4,
  parameter int IDX_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic [MAX_BYTES*8-1:0] frame_i,
  input  logic [IDX_W-1:0]       idx_i,
  output logic [LEN_W-1:0]       len_o,
  output logic [7:0]             byte_o
);
  logic [MAX_BYTES*8-1:0] frame_q;
  logic [LEN_W-1:0]       len_q;
  logic [7:0]             bytes [MAX_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      len_q   <= '0;
    end else if (load_i) begin
      frame_q <= frame_i;
      len_q   <= len_i;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_unpack
    assign bytes[g] = frame_q[g*8 +: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int k = 0; k < MAX_BYTES; k++)
      if (idx_i == IDX_W'(k)) byte_o = bytes[k];
  end

  assign len_o = len_q;
endmodule

// File: rtl/resp_tx_fsm.sv
module resp_tx_fsm
  import resp_tx_pkg::*;
#(
  parameter int MAX_BYTES = 9,
  parameter int LEN_W     = 4,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_in_i,
  input  logic [LEN_W-1:0] len_q_i,
  input  logic             ack_i,
  output logic             load_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             syn_o,
  output logic             busy_o,
  output logic             done_o
);
  tx_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_q;
  logic             done_q;
  logic             len_ok;
  logic             at_last;

  assign len_ok  = (len_in_i != '0) && (len_in_i <= LEN_W'(MAX_BYTES));
  assign load_o  = start_i && (state_q == ST_IDLE) && len_ok;
  assign at_last = (LEN_W'(idx_q) + LEN_W'(1)) == len_q_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_OFFER;
          idx_q   <= '0;
          last_q  <= 1'b0;
        end
        ST_OFFER: if (ack_i) begin
          state_q <= ST_RELEASE;
          last_q  <= at_last;
          if (!at_last) idx_q <= idx_q + IDX_W'(1);
        end
        ST_RELEASE: if (!ack_i) begin
          if (last_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_OFFER;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o  = idx_q;
  assign syn_o  = (state_q == ST_OFFER);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/resp_tx_top.sv
module resp_tx_top #(
  parameter int MAX_BYTES = 9,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [LEN_W-1:0]       frame_len_i,
  input  logic [MAX_BYTES*8-1:0] frame_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [7:0]             tx_data_o,
  output logic                   tx_syn_o,
  input  logic                   tx_ack_i
);
  logic             load;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] len_q;

  resp_tx_fsm #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .len_in_i (frame_len_i),
    .len_q_i  (len_q),
    .ack_i    (tx_ack_i),
    .load_o   (load),
    .idx_o    (idx),
    .syn_o    (tx_syn_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  resp_tx_store #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .len_i   (frame_len_i),
    .frame_i (frame_i),
    .idx_i   (idx),
    .len_o   (len_q),
    .byte_o  (tx_data_o)
  );
endmodule

// File: rtl/resp_tx_checker.sv
module resp_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] tx_data_o,
  input logic       tx_syn_o,
  input logic       tx_ack_i
);
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_syn_o && $past(tx_syn_o)) |-> $stable(tx_data_o)); // R2
  AST_SYN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_syn_o && tx_ack_i) |=> !tx_syn_o); // R3
  AST_NO_RAISE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_syn_o) |-> !$past(tx_ack_i)); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_SYN_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_syn_o |-> busy_o); // R1
endmodule

bind resp_tx_top resp_tx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .tx_data_o (tx_data_o),
  .tx_syn_o  (tx_syn_o),
  .tx_ack_i  (tx_ack_i)
);

// File: tb/resp_tx_top_tb.sv
module resp_tx_top_tb;
  localparam int MAXB = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    frame_len_i = '0;
  logic [MAXB*8-1:0] frame_i = '0;
  logic          busy_o, done_o, tx_syn_o;
  logic [7:0]    tx_data_o;
  logic          tx_ack_i = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  resp_tx_top #(.MAX_BYTES(MAXB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_len_i(frame_len_i),
    .frame_i(frame_i), .busy_o(busy_o), .done_o(done_o),
    .tx_data_o(tx_data_o), .tx_syn_o(tx_syn_o), .tx_ack_i(tx_ack_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [MAXB*8-1:0] make_frame(input int len, input bit mid55);
    logic [MAXB*8-1:0] f = '0;
    for (int k = 0; k < len; k++) f[k*8 +: 8] = 8'($urandom);
    f[7:0] = 8'haa;
    f[(len-1)*8 +: 8] = 8'h55;
    if (mid55 && len > 2) f[8 +: 8] = 8'h55;
    return f;
  endfunction

  task automatic send_frame(input int len, input logic [MAXB*8-1:0] fr, input bit disturb);
    @(negedge clk);
    frame_i = fr; frame_len_i = 4'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
    for (int i = 0; i < len; i++) begin
      logic [7:0] expb = fr[i*8 +: 8];
      check(tx_syn_o == 1'b1, "R4 syn raised for byte", tx_syn_o, 1);
      check(tx_data_o == expb, "R5 byte order", tx_data_o, expb);
      if (disturb && i == 1) begin
        start_i = 1'b1; frame_len_i = 4'd3; frame_i = {MAXB{8'h3c}};
        @(negedge clk);
        start_i = 1'b0;
        check(tx_data_o == expb, "R7 start while busy ignored", tx_data_o, expb);
      end
      for (int w = $urandom_range(0, 3); w > 0; w--) begin
        @(negedge clk);
        if (disturb) frame_i = {$urandom, $urandom, $urandom};
        check(tx_syn_o == 1'b1 && tx_data_o == expb, "R2 stable while waiting", tx_data_o, expb);
      end
      tx_ack_i = 1'b1;
      @(negedge clk);
      check(tx_syn_o == 1'b0, "R3 syn drops after ack", tx_syn_o, 0);
      for (int w = $urandom_range(0, 3); w > 0; w--) begin
        @(negedge clk);
        check(tx_syn_o == 1'b0, "R4 syn held low while ack high", tx_syn_o, 0);
      end
      tx_ack_i = 1'b0;
      @(negedge clk);
      if (i == len - 1) begin
        check(done_o == 1'b1, "R6 done pulse", done_o, 1);
        check(busy_o == 1'b0, "R6 busy falls with done", busy_o, 0);
        check(tx_syn_o == 1'b0, "R5 no byte after last", tx_syn_o, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R6 done lasts one cycle", done_o, 0);
      end else begin
        check(busy_o == 1'b1, "R6 busy held mid frame", busy_o, 1);
      end
    end
  endtask

  task automatic bad_start(input int len);
    @(negedge clk);
    frame_len_i = 4'(len); frame_i = make_frame(3, 0); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b0 && tx_syn_o == 1'b0, "R8 illegal length ignored", busy_o, 0);
    @(negedge clk);
    check(tx_syn_o == 1'b0, "R8 still idle", tx_syn_o, 0);
  endtask

  initial begin
    int lens[4] = '{3, 4, 5, 9};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busy_o == 0 && tx_syn_o == 0 && done_o == 0, "R1 reset state", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_syn_o == 0, "R1 idle after reset", tx_syn_o, 0);
    send_frame(3, make_frame(3, 0), 0);
    send_frame(9, make_frame(9, 1), 0);
    send_frame(5, make_frame(5, 1), 1);
    send_frame(1, 72'h55, 0);
    bad_start(0);
    bad_start(10);
    bad_start(15);
    for (int n = 0; n < 40; n++) begin
      int l = lens[$urandom_range(0, 3)];
      send_frame(l, make_frame(l, $urandom_range(0, 1)), $urandom_range(0, 1));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule